// File: doc/BRIEF.md
# Byte-Wide Data EEPROM Register Controller

This block sits between a small processor's byte-wide peripheral bus and a 128-byte on-chip data memory that behaves like EEPROM. Software reaches it through three byte registers picked by a two-bit select: an address pointer, a data holding register and a control register. A read fetches the addressed byte into the data register in one cycle. Programming clears a byte (erase), clears bits in it (write), or replaces it outright (combined erase and write). After that, the memory stays busy for a programmable number of clock cycles.

Starting a program operation takes two steps. First software sets the arming bit. Then, within the next few cycles, it sets the program bit. While the memory is busy, the mode field cannot be changed and read requests are dropped. A synchronous reset that arrives during programming does not disturb the running timer or the selected mode. A level-sensitive ready interrupt is asserted while the memory is idle, provided the interrupt enable bit and the global interrupt input are both high.

Top module: `eeprom_reg_ctrl`

## Requirements
- R1: The address register (select 0) keeps 7 bits, and bit 7 reads back as zero. Bytes 0 to 127 are addressed linearly, and the register resets to 0.
- R2: A write to the data register (select 1) reads back unchanged. A control write with bit 0 set while idle loads the addressed byte into the data register on that clock edge. Bytes that have never been programmed read 0xFF.
- R3: In the control register (select 2), bits 7:6 and bit 0 always read as zero. Bit 0 is the read request and clears itself.
- R4: Control bit 2 (arming) reads 1 for 4 cycles after it is written and then clears. A control write with bit 1 (program) starts an operation only if the arming bit is still set when the program write arrives. Otherwise nothing happens.
- R5: With mode bits [5:4] = 00, the byte in the data register is stored at the address. Control bit 1 then reads 1 for exactly ATOMIC_CYC cycles.
- R6: With mode 01, the addressed byte becomes 0xFF. The busy time is SPLIT_CYC cycles.
- R7: With mode 10, the addressed byte becomes its old value ANDed with the data register. The busy time is SPLIT_CYC cycles.
- R8: Mode 11 is reserved. A program request in that mode starts nothing and leaves the memory unchanged.
- R9: While busy, writes to the mode bits are ignored.
- R10: Reset clears the address, data, interrupt enable and arming state. It clears the mode to 00 only if no program operation is running. Otherwise the mode and the busy state are kept.
- R11: `ready_irq` is high exactly when control bit 3 is set, `gie` is high and the memory is not busy.
- R12: While busy, a read request leaves the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 control |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_rd | input | 1 | Read strobe; `reg_rdata` is zero when low |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| gie | input | 1 | Global interrupt enable |
| ready_irq | output | 1 | Level ready interrupt |

## Verification
The bench builds the block with ATOMIC_CYC = 12 and SPLIT_CYC = 7, keeping ARM_WINDOW at 4. These short, unequal busy times let it sample the busy bit on the last busy cycle and on the first idle cycle of each mode, and tell an atomic duration apart from a split one. The same short timing makes it practical to land a reset and a locked mode write in the middle of an operation. The arming test writes the program bit on the fifth cycle after the arming write, which is one cycle past the window.

// File: rtl/ee_pkg.sv
package ee_pkg;
   typedef enum logic [1:0] {
      PM_ATOMIC = 2'b00,
      PM_ERASE  = 2'b01,
      PM_WRITE  = 2'b10,
      PM_RSVD   = 2'b11
   } pmode_e;

   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_DATA = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } regsel_e;

   localparam int CB_RDREQ = 0;
   localparam int CB_PROG  = 1;
   localparam int CB_ARM   = 2;
   localparam int CB_RIE   = 3;
   localparam int CB_MODE  = 4;
endpackage

// File: rtl/ee_arm_window.sv
module ee_arm_window #(
   parameter int WINDOW = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic consume,
   output logic armed
);
   localparam int W_W = $clog2(WINDOW + 1);

   if (WINDOW < 1) begin : g_bad_window
      $error("ee_arm_window: WINDOW must be at least 1");
   end

   logic [W_W-1:0] win_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       win_q <= '0;
      else if (consume) win_q <= '0;
      else if (arm)     win_q <= W_W'(WINDOW);
      else if (win_q != '0) win_q <= win_q - 1'b1;
   end

   assign armed = (win_q != '0);

   a_r4_used_once: assert property (@(posedge clk) disable iff (!rst_n)
      consume |=> !armed);
   a_r4_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && !consume) |=> armed);
endmodule

// File: rtl/ee_prog_timer.sv
module ee_prog_timer
   import ee_pkg::*;
#(
   parameter int ATOMIC_CYC = 34,
   parameter int SPLIT_CYC  = 18
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  pmode_e mode,
   output logic   busy
);
   localparam int MAX_CYC = (ATOMIC_CYC > SPLIT_CYC) ? ATOMIC_CYC : SPLIT_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   if (ATOMIC_CYC < 1 || SPLIT_CYC < 1) begin : g_bad_len
      $error("ee_prog_timer: busy lengths must be at least 1 cycle");
   end

   logic [CNT_W-1:0] len;
   if (ATOMIC_CYC == SPLIT_CYC) begin : g_one_len
      assign len = CNT_W'(ATOMIC_CYC);
   end else begin : g_two_len
      assign len = (mode == PM_ATOMIC) ? CNT_W'(ATOMIC_CYC) : CNT_W'(SPLIT_CYC);
   end

   // Deliberately untouched by rst_n: a running operation survives reset.
   logic [CNT_W-1:0] cnt_q = '0;

   always_ff @(posedge clk) begin
      if (start)             cnt_q <= len;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);

   a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   a_r5_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !busy) |=> !busy);
endmodule

// File: rtl/ee_array.sv
module ee_array
   import ee_pkg::*;
#(
   parameter int AW = 7,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          op_en,
   input  pmode_e        op,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   if (DEPTH > 4096) begin : g_bad_depth
      $error("ee_array: depth too large");
   end

   logic [DW-1:0] cells [DEPTH];
   logic [DW-1:0] cur;
   logic [DW-1:0] nxt;

   assign cur = cells[addr];

   always_comb begin
      unique case (op)
         PM_ATOMIC: nxt = wdata;
         PM_ERASE:  nxt = '1;
         PM_WRITE:  nxt = cur & wdata;
         default:   nxt = cur;
      endcase
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      logic [DW-1:0] byte_q = '1;
      always_ff @(posedge clk) begin
         if (op_en && (addr == AW'(g))) byte_q <= nxt;
      end
      assign cells[g] = byte_q;
   end

   assign rdata = cur;
endmodule

// File: rtl/eeprom_reg_ctrl.sv
module eeprom_reg_ctrl
   import ee_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int DATA_W     = 8,
   parameter int ATOMIC_CYC = 34,
   parameter int SPLIT_CYC  = 18,
   parameter int ARM_WINDOW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_sel,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              gie,
   output logic              ready_irq
);
   if (DATA_W != 8) begin : g_bad_dw
      $error("eeprom_reg_ctrl: control layout needs DATA_W == 8");
   end
   if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_aw
      $error("eeprom_reg_ctrl: ADDR_W must lie in 1..DATA_W");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   pmode_e            mode_q;
   logic              rie_q;
   logic              busy;
   logic              armed;
   logic [DATA_W-1:0] arr_rdata;

   logic   addr_wr, data_wr, ctrl_wr;
   pmode_e mode_req;
   logic   start, rd_req;

   assign addr_wr  = reg_wr && (regsel_e'(reg_sel) == SEL_ADDR);
   assign data_wr  = reg_wr && (regsel_e'(reg_sel) == SEL_DATA);
   assign ctrl_wr  = reg_wr && (regsel_e'(reg_sel) == SEL_CTRL);
   assign mode_req = busy ? mode_q : pmode_e'(reg_wdata[CB_MODE +: 2]);
   assign start    = ctrl_wr && reg_wdata[CB_PROG] && armed && !busy
                     && (mode_req != PM_RSVD);
   assign rd_req   = ctrl_wr && reg_wdata[CB_RDREQ] && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         rie_q  <= 1'b0;
      end else begin
         if (addr_wr) addr_q <= reg_wdata[ADDR_W-1:0];
         if (data_wr)     data_q <= reg_wdata;
         else if (rd_req) data_q <= arr_rdata;
         if (ctrl_wr) rie_q <= reg_wdata[CB_RIE];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         if (!busy) mode_q <= PM_ATOMIC;
      end else if (ctrl_wr && !busy) begin
         mode_q <= mode_req;
      end
   end

   ee_arm_window #(.WINDOW(ARM_WINDOW)) u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (ctrl_wr && reg_wdata[CB_ARM]),
      .consume (start),
      .armed   (armed)
   );

   ee_prog_timer #(.ATOMIC_CYC(ATOMIC_CYC), .SPLIT_CYC(SPLIT_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .mode  (mode_req),
      .busy  (busy)
   );

   ee_array #(.AW(ADDR_W), .DW(DATA_W)) u_arr (
      .clk   (clk),
      .op_en (start),
      .op    (mode_req),
      .addr  (addr_q),
      .wdata (data_q),
      .rdata (arr_rdata)
   );

   logic [DATA_W-1:0] ctrl_view;
   assign ctrl_view = {2'b00, mode_q, rie_q, armed, busy, 1'b0};

   always_comb begin
      reg_rdata = '0;
      if (reg_rd) begin
         unique case (regsel_e'(reg_sel))
            SEL_ADDR: reg_rdata = DATA_W'(addr_q);
            SEL_DATA: reg_rdata = data_q;
            SEL_CTRL: reg_rdata = ctrl_view;
            default:  reg_rdata = '0;
         endcase
      end
   end

   assign ready_irq = rie_q && gie && !busy;

   a_r4_start_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(armed));
   a_r8_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !busy && reg_wdata[CB_MODE +: 2] == 2'b11) |=> !busy);
   a_r9_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(mode_q));
   a_r11_irq_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !ready_irq);
   a_r12_read_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ctrl_wr && reg_wdata[CB_RDREQ]) |=> $stable(data_q));
   a_r3_ctrl_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_sel == 2'd2) |-> (reg_rdata[7:6] == 2'b00 && !reg_rdata[0]));
endmodule

// File: tb/sim_eeprom_reg_ctrl.sv
`timescale 1ns/1ps
module sim_eeprom_reg_ctrl;
   localparam int LA = 12;
   localparam int LS = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_sel = 2'd3;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       gie = 1'b0;
   logic       ready_irq;

   int errors = 0;
   int checks = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;

   eeprom_reg_ctrl #(.ATOMIC_CYC(LA), .SPLIT_CYC(LS), .ARM_WINDOW(4)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .gie(gie), .ready_irq(ready_irq));

   // Monitor: compares each read against the scoreboard queue.
   always @(negedge clk) begin
      if (reg_rd) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected read: actual %02h expected none", reg_rdata);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (reg_rdata !== e) begin
               errors++;
               $display("FAIL %s: actual %02h expected %02h", t, reg_rdata, e);
            end
         end
      end
   end

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0; reg_sel = 2'd3;
   endtask

   task automatic rd(input logic [1:0] s, input logic [7:0] e, input string t);
      exp_q.push_back(e); tag_q.push_back(t);
      reg_sel = s; reg_rd = 1'b1;
      @(posedge clk); #1;
      reg_rd = 1'b0; reg_sel = 2'd3;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
   endtask

   task automatic chk_irq(input logic e, input string t);
      checks++;
      if (ready_irq !== e) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b", t, ready_irq, e);
      end
   endtask

   task automatic summary();
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      #1;
      do_reset();
      // R10 reset state
      rd(2'd2, 8'h00, "R10 ctrl after reset");
      rd(2'd0, 8'h00, "R1 addr after reset");
      chk_irq(1'b0, "R11 irq after reset");
      // R1 address width
      wr(2'd0, 8'hC5);
      rd(2'd0, 8'h45, "R1 addr bit7 dropped");
      // R2 data register and read
      wr(2'd1, 8'h3C);
      rd(2'd1, 8'h3C, "R2 data readback");
      wr(2'd0, 8'd5);
      wr(2'd2, 8'h01);
      rd(2'd1, 8'hFF, "R2 fresh byte read");
      rd(2'd2, 8'h00, "R3 read bit self-clears");
      wr(2'd2, 8'hC0);
      rd(2'd2, 8'h00, "R3 reserved bits zero");
      // R5 atomic store and busy length
      wr(2'd0, 8'd10);
      wr(2'd1, 8'h5A);
      wr(2'd2, 8'h04);
      rd(2'd2, 8'h04, "R4 arm bit visible");
      wr(2'd2, 8'h02);
      idle(LA - 1);
      rd(2'd2, 8'h02, "R5 busy on last atomic cycle");
      rd(2'd2, 8'h00, "R5 idle after atomic time");
      wr(2'd2, 8'h01);
      rd(2'd1, 8'h5A, "R5 atomic stored value");
      // R6 erase only
      wr(2'd2, 8'h14);
      wr(2'd2, 8'h12);
      idle(LS - 1);
      rd(2'd2, 8'h12, "R6 busy on last erase cycle");
      rd(2'd2, 8'h10, "R6 idle after erase time");
      wr(2'd2, 8'h11);
      rd(2'd1, 8'hFF, "R6 erased byte");
      // R7 write only, R9 mode lock, R12 read lock
      wr(2'd1, 8'h0F);
      wr(2'd2, 8'h24);
      wr(2'd2, 8'h22);
      wr(2'd0, 8'd5);
      wr(2'd2, 8'h31);
      rd(2'd1, 8'h0F, "R12 read ignored while busy");
      rd(2'd2, 8'h22, "R9 mode write ignored while busy");
      idle(LS);
      wr(2'd0, 8'd10);
      wr(2'd1, 8'hF3);
      wr(2'd2, 8'h24);
      wr(2'd2, 8'h22);
      idle(LS);
      wr(2'd2, 8'h21);
      rd(2'd1, 8'h03, "R7 write-only ANDs bits");
      // R4 late program request
      wr(2'd1, 8'h77);
      wr(2'd0, 8'd20);
      wr(2'd2, 8'h04);
      idle(4);
      wr(2'd2, 8'h02);
      rd(2'd2, 8'h00, "R4 late program ignored");
      wr(2'd2, 8'h01);
      rd(2'd1, 8'hFF, "R4 byte untouched");
      // R8 reserved mode
      wr(2'd2, 8'h34);
      wr(2'd2, 8'h32);
      rd(2'd2, 8'h34, "R8 reserved mode no start");
      wr(2'd2, 8'h01);
      rd(2'd1, 8'hFF, "R8 byte untouched");
      idle(4);
      // R11 interrupt
      wr(2'd2, 8'h08);
      chk_irq(1'b0, "R11 irq gated by gie");
      gie = 1'b1; #1;
      chk_irq(1'b1, "R11 irq when ready");
      wr(2'd2, 8'h0C);
      wr(2'd2, 8'h0A);
      chk_irq(1'b0, "R11 irq low while busy");
      idle(LA);
      chk_irq(1'b1, "R11 irq back after done");
      // R10 reset during programming
      wr(2'd0, 8'd30);
      wr(2'd2, 8'h1C);
      wr(2'd2, 8'h1A);
      do_reset();
      rd(2'd2, 8'h12, "R10 mode kept in busy reset");
      chk_irq(1'b0, "R10 enable cleared by reset");
      idle(LS);
      rd(2'd2, 8'h10, "R10 operation completed");
      do_reset();
      rd(2'd2, 8'h00, "R10 mode cleared in idle reset");
      idle(2);
      summary();
      $finish;
   end
endmodule